// File: doc/BRIEF.md
# Paired Group Clock and Control Distributor

This block feeds the shared controls of a programmable logic array whose logic cells are split into two equal groups, A and B. Each group gets its own control cell. That cell picks the group clock from one of two dedicated clock pins or from a clock built by a product term of the array. It hands an I/O-side copy of that clock, with selectable polarity, to the group's input registers and latches. It also fans out three things to every logic cell of its group: a global reset sum, a global preset sum, and a fast register-type term.

Clocks are carried as sampled levels, so the block needs no clock gating. Next to each level it raises a one-cycle tick when that level rises, and cells use the tick as a clock enable on the system clock. The clock source and the I/O polarity are static settings taken in while reset is held. Each logic cell's local reset and local preset are merged with its group's global terms at the cell boundary. Generating the product terms themselves lies outside this block.

Top module: `glb_ctl_pair`

## Requirements
- R1: Each group's logic-cell clock level follows the source chosen by its 2-bit source code: 0 selects pin clock 1, 1 selects pin clock 2, 2 selects that group's product-term clock, and the unused code 3 falls back to pin clock 1.
- R2: Each group's I/O clock level equals its logic-cell clock level when the polarity bit is 0, and its inverse when the bit is 1, so a falling source edge becomes the I/O capture edge.
- R3: The source code and polarity bit are loaded on every clock edge while rst is high and are held after rst falls; changing them afterwards has no effect on either clock level.
- R4: A tick output is high for exactly one cycle in the first cycle in which its clock level is 1 after having been 0 at the previous edge. Ticks stay 0 while rst is high, and a level that is already 1 when reset is released raises no tick.
- R5: A logic cell's effective reset is high when any reset product term of its own group is high or when its own local reset is high.
- R6: A logic cell's effective preset is high when any preset product term of its own group is high or when its own local preset is high, provided its effective reset is low.
- R7: Effective reset overrides effective preset: a cell never shows both at once.
- R8: Every logic cell's register-type output equals its group's register-type term.
- R9: Cell indices below N_LC/2 belong to group A and the rest belong to group B. No clock, reset, preset or register-type change applied only to group B alters any group A output, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all clock levels |
| rst | input | 1 | Synchronous active-high reset; configuration is loaded while it is high |
| cfg_src_a | input | 2 | Group A clock source code |
| cfg_iofall_a | input | 1 | Group A I/O clock polarity (1 = falling edge) |
| cfg_src_b | input | 2 | Group B clock source code |
| cfg_iofall_b | input | 1 | Group B I/O clock polarity (1 = falling edge) |
| pin_clk1 | input | 1 | Level of dedicated clock pin 1 |
| pin_clk2 | input | 1 | Level of dedicated clock pin 2 |
| pclk_pt_a | input | 1 | Group A product-term clock level |
| pclk_pt_b | input | 1 | Group B product-term clock level |
| rst_pt_a | input | N_RST_PT | Group A global reset product terms |
| rst_pt_b | input | N_RST_PT | Group B global reset product terms |
| pre_pt_a | input | N_PRE_PT | Group A global preset product terms |
| pre_pt_b | input | N_PRE_PT | Group B global preset product terms |
| rtype_pt_a | input | 1 | Group A fast register-type term |
| rtype_pt_b | input | 1 | Group B fast register-type term |
| lc_rst_loc | input | N_LC | Local reset of each logic cell |
| lc_pre_loc | input | N_LC | Local preset of each logic cell |
| lc_clk_a | output | 1 | Group A logic-cell clock level |
| lc_clk_b | output | 1 | Group B logic-cell clock level |
| io_clk_a | output | 1 | Group A I/O clock level after polarity |
| io_clk_b | output | 1 | Group B I/O clock level after polarity |
| lc_tick_a | output | 1 | Group A logic-cell clock rise strobe |
| lc_tick_b | output | 1 | Group B logic-cell clock rise strobe |
| io_tick_a | output | 1 | Group A I/O clock rise strobe |
| io_tick_b | output | 1 | Group B I/O clock rise strobe |
| lc_rst_eff | output | N_LC | Effective reset of each logic cell |
| lc_pre_eff | output | N_LC | Effective preset of each logic cell |
| lc_rtype | output | N_LC | Register-type control of each logic cell |

## Verification
The bench builds the block with N_LC = 6, N_RST_PT = 3 and N_PRE_PT = 2. Three cells per group is enough to show the A/B boundary falling between index 2 and index 3, while keeping the expected vectors short. Three reset terms check that the sum picks up a term other than the first, and two preset terms check the same for presets. With these sizes every cell index can be checked one at a time when a single local reset or the reset-over-preset rule is exercised on one cell.

// File: rtl/gcp_pkg.sv
package gcp_pkg;

    localparam int N_GRP = 2;

    typedef enum logic [1:0] {
        SRC_PIN1  = 2'd0,
        SRC_PIN2  = 2'd1,
        SRC_PTERM = 2'd2,
        SRC_RSVD  = 2'd3
    } clk_src_e;

    typedef struct packed {
        clk_src_e src;
        logic     io_fall;
    } grp_cfg_t;

    typedef struct packed {
        logic lc_lvl;
        logic io_lvl;
    } clk_lvl_t;

    typedef struct packed {
        logic lc_tick;
        logic io_tick;
    } clk_tick_t;

    function automatic logic pick_src(clk_src_e s, logic p1, logic p2, logic pt);
        logic r;
        case (s)
            SRC_PIN2:  r = p2;
            SRC_PTERM: r = pt;
            default:   r = p1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gcp_cfg_hold.sv
module gcp_cfg_hold
    import gcp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  grp_cfg_t cfg_in,
    output grp_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/gcp_clk_route.sv
module gcp_clk_route
    import gcp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  grp_cfg_t  cfg,
    input  logic      pin1,
    input  logic      pin2,
    input  logic      pterm,
    output clk_lvl_t  lvl,
    output clk_tick_t tick
);

    clk_lvl_t prev_q;

    always_comb begin
        lvl.lc_lvl = pick_src(cfg.src, pin1, pin2, pterm);
        lvl.io_lvl = lvl.lc_lvl ^ cfg.io_fall;
    end

    // Previous level is tracked during reset too, so a level already high
    // at release produces no spurious strobe.
    always_ff @(posedge clk) begin
        prev_q <= lvl;
    end

    always_comb begin
        tick.lc_tick = lvl.lc_lvl & ~prev_q.lc_lvl & ~rst;
        tick.io_tick = lvl.io_lvl & ~prev_q.io_lvl & ~rst;
    end

endmodule

// File: rtl/gcp_ctl_fan.sv
module gcp_ctl_fan #(
    parameter int N_CELL   = 10,
    parameter int N_RST_PT = 2,
    parameter int N_PRE_PT = 2
) (
    input  logic [N_RST_PT-1:0] rst_pt,
    input  logic [N_PRE_PT-1:0] pre_pt,
    input  logic                rtype_pt,
    input  logic [N_CELL-1:0]   loc_rst,
    input  logic [N_CELL-1:0]   loc_pre,
    output logic [N_CELL-1:0]   eff_rst,
    output logic [N_CELL-1:0]   eff_pre,
    output logic [N_CELL-1:0]   rtype
);

    logic g_rst;
    logic g_pre;

    assign g_rst = |rst_pt;
    assign g_pre = |pre_pt;

    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
        assign eff_rst[c] = g_rst | loc_rst[c];
        assign eff_pre[c] = (g_pre | loc_pre[c]) & ~eff_rst[c];
        assign rtype[c]   = rtype_pt;
    end

endmodule

// File: rtl/gcp_group.sv
module gcp_group
    import gcp_pkg::*;
#(
    parameter int N_CELL   = 10,
    parameter int N_RST_PT = 2,
    parameter int N_PRE_PT = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  grp_cfg_t            cfg_in,
    input  logic                pin1,
    input  logic                pin2,
    input  logic                pterm,
    input  logic [N_RST_PT-1:0] rst_pt,
    input  logic [N_PRE_PT-1:0] pre_pt,
    input  logic                rtype_pt,
    input  logic [N_CELL-1:0]   loc_rst,
    input  logic [N_CELL-1:0]   loc_pre,
    output clk_lvl_t            lvl,
    output clk_tick_t           tick,
    output logic [N_CELL-1:0]   eff_rst,
    output logic [N_CELL-1:0]   eff_pre,
    output logic [N_CELL-1:0]   rtype
);

    grp_cfg_t cfg_q;

    gcp_cfg_hold u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    gcp_clk_route u_clk (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg_q),
        .pin1  (pin1),
        .pin2  (pin2),
        .pterm (pterm),
        .lvl   (lvl),
        .tick  (tick)
    );

    gcp_ctl_fan #(
        .N_CELL   (N_CELL),
        .N_RST_PT (N_RST_PT),
        .N_PRE_PT (N_PRE_PT)
    ) u_fan (
        .rst_pt   (rst_pt),
        .pre_pt   (pre_pt),
        .rtype_pt (rtype_pt),
        .loc_rst  (loc_rst),
        .loc_pre  (loc_pre),
        .eff_rst  (eff_rst),
        .eff_pre  (eff_pre),
        .rtype    (rtype)
    );

endmodule

// File: rtl/glb_ctl_pair.sv
module glb_ctl_pair
    import gcp_pkg::*;
#(
    parameter int N_LC     = 20,
    parameter int N_RST_PT = 2,
    parameter int N_PRE_PT = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cfg_src_a,
    input  logic                cfg_iofall_a,
    input  logic [1:0]          cfg_src_b,
    input  logic                cfg_iofall_b,
    input  logic                pin_clk1,
    input  logic                pin_clk2,
    input  logic                pclk_pt_a,
    input  logic                pclk_pt_b,
    input  logic [N_RST_PT-1:0] rst_pt_a,
    input  logic [N_RST_PT-1:0] rst_pt_b,
    input  logic [N_PRE_PT-1:0] pre_pt_a,
    input  logic [N_PRE_PT-1:0] pre_pt_b,
    input  logic                rtype_pt_a,
    input  logic                rtype_pt_b,
    input  logic [N_LC-1:0]     lc_rst_loc,
    input  logic [N_LC-1:0]     lc_pre_loc,
    output logic                lc_clk_a,
    output logic                lc_clk_b,
    output logic                io_clk_a,
    output logic                io_clk_b,
    output logic                lc_tick_a,
    output logic                lc_tick_b,
    output logic                io_tick_a,
    output logic                io_tick_b,
    output logic [N_LC-1:0]     lc_rst_eff,
    output logic [N_LC-1:0]     lc_pre_eff,
    output logic [N_LC-1:0]     lc_rtype
);

    localparam int HALF = N_LC / 2;

    grp_cfg_t                 cfg_g    [N_GRP];
    logic                     pterm_g  [N_GRP];
    logic [N_RST_PT-1:0]      rpt_g    [N_GRP];
    logic [N_PRE_PT-1:0]      ppt_g    [N_GRP];
    logic                     rtpt_g   [N_GRP];
    clk_lvl_t                 lvl_g    [N_GRP];
    clk_tick_t                tick_g   [N_GRP];

    assign cfg_g[0]   = '{src: clk_src_e'(cfg_src_a), io_fall: cfg_iofall_a};
    assign cfg_g[1]   = '{src: clk_src_e'(cfg_src_b), io_fall: cfg_iofall_b};
    assign pterm_g[0] = pclk_pt_a;
    assign pterm_g[1] = pclk_pt_b;
    assign rpt_g[0]   = rst_pt_a;
    assign rpt_g[1]   = rst_pt_b;
    assign ppt_g[0]   = pre_pt_a;
    assign ppt_g[1]   = pre_pt_b;
    assign rtpt_g[0]  = rtype_pt_a;
    assign rtpt_g[1]  = rtype_pt_b;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        gcp_group #(
            .N_CELL   (HALF),
            .N_RST_PT (N_RST_PT),
            .N_PRE_PT (N_PRE_PT)
        ) u_grp (
            .clk      (clk),
            .rst      (rst),
            .cfg_in   (cfg_g[g]),
            .pin1     (pin_clk1),
            .pin2     (pin_clk2),
            .pterm    (pterm_g[g]),
            .rst_pt   (rpt_g[g]),
            .pre_pt   (ppt_g[g]),
            .rtype_pt (rtpt_g[g]),
            .loc_rst  (lc_rst_loc[g*HALF +: HALF]),
            .loc_pre  (lc_pre_loc[g*HALF +: HALF]),
            .lvl      (lvl_g[g]),
            .tick     (tick_g[g]),
            .eff_rst  (lc_rst_eff[g*HALF +: HALF]),
            .eff_pre  (lc_pre_eff[g*HALF +: HALF]),
            .rtype    (lc_rtype[g*HALF +: HALF])
        );
    end

    assign lc_clk_a  = lvl_g[0].lc_lvl;
    assign io_clk_a  = lvl_g[0].io_lvl;
    assign lc_clk_b  = lvl_g[1].lc_lvl;
    assign io_clk_b  = lvl_g[1].io_lvl;
    assign lc_tick_a = tick_g[0].lc_tick;
    assign io_tick_a = tick_g[0].io_tick;
    assign lc_tick_b = tick_g[1].lc_tick;
    assign io_tick_b = tick_g[1].io_tick;

endmodule

// File: rtl/glb_ctl_pair_chk.sv
module glb_ctl_pair_chk #(
    parameter int N_LC     = 20,
    parameter int N_RST_PT = 2,
    parameter int N_PRE_PT = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [N_RST_PT-1:0] rst_pt_a,
    input logic [N_RST_PT-1:0] rst_pt_b,
    input logic [N_PRE_PT-1:0] pre_pt_a,
    input logic [N_PRE_PT-1:0] pre_pt_b,
    input logic [N_LC-1:0]     lc_rst_loc,
    input logic                lc_clk_a,
    input logic                io_clk_a,
    input logic                io_clk_b,
    input logic                lc_tick_a,
    input logic                io_tick_b,
    input logic [N_LC-1:0]     lc_rst_eff,
    input logic [N_LC-1:0]     lc_pre_eff
);

    localparam int HALF = N_LC / 2;

    AST_LC_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
        lc_tick_a |=> !lc_tick_a); // R4

    AST_IO_TICK_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
        io_tick_b |-> !$past(io_clk_b)); // R4

    AST_POL_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((io_clk_a ^ lc_clk_a) == $past(io_clk_a ^ lc_clk_a))); // R3

    for (genvar c = 0; c < N_LC; c++) begin : g_cell
        localparam bit IN_A = (c < HALF);
        logic grp_rst;
        logic grp_pre;
        logic other_rst;
        assign grp_rst   = IN_A ? (|rst_pt_a) : (|rst_pt_b);
        assign grp_pre   = IN_A ? (|pre_pt_a) : (|pre_pt_b);
        assign other_rst = IN_A ? (|rst_pt_b) : (|rst_pt_a);

        AST_GRST_REACH: assert property (@(posedge clk) disable iff (rst)
            grp_rst |-> lc_rst_eff[c]); // R5

        AST_GPRE_REACH: assert property (@(posedge clk) disable iff (rst)
            (grp_pre && !grp_rst && !lc_rst_loc[c]) |-> lc_pre_eff[c]); // R6

        AST_RST_OVER_PRE: assert property (@(posedge clk) disable iff (rst)
            lc_rst_eff[c] |-> !lc_pre_eff[c]); // R7

        AST_GRP_ISO: assert property (@(posedge clk) disable iff (rst)
            (other_rst && !grp_rst && !lc_rst_loc[c]) |-> !lc_rst_eff[c]); // R9
    end

endmodule

bind glb_ctl_pair glb_ctl_pair_chk #(
    .N_LC     (N_LC),
    .N_RST_PT (N_RST_PT),
    .N_PRE_PT (N_PRE_PT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rst_pt_a   (rst_pt_a),
    .rst_pt_b   (rst_pt_b),
    .pre_pt_a   (pre_pt_a),
    .pre_pt_b   (pre_pt_b),
    .lc_rst_loc (lc_rst_loc),
    .lc_clk_a   (lc_clk_a),
    .io_clk_a   (io_clk_a),
    .io_clk_b   (io_clk_b),
    .lc_tick_a  (lc_tick_a),
    .io_tick_b  (io_tick_b),
    .lc_rst_eff (lc_rst_eff),
    .lc_pre_eff (lc_pre_eff)
);

// File: tb/glb_ctl_pair_tb.sv
module glb_ctl_pair_tb;

    localparam int N_LC     = 6;
    localparam int N_RST_PT = 3;
    localparam int N_PRE_PT = 2;
    localparam int N_VEC    = 8;

    // {src[1:0], io_fall, pin1, pin2, pterm, expected lc level}
    localparam logic [6:0] VEC [N_VEC] = '{
        7'b00_0_100_1,
        7'b00_0_011_0,
        7'b01_0_010_1,
        7'b01_1_101_0,
        7'b10_0_001_1,
        7'b10_1_110_0,
        7'b11_0_100_1,
        7'b11_1_011_0
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [1:0]          cfg_src_a = 2'd0;
    logic                cfg_iofall_a = 1'b0;
    logic [1:0]          cfg_src_b = 2'd0;
    logic                cfg_iofall_b = 1'b0;
    logic                pin_clk1 = 1'b0;
    logic                pin_clk2 = 1'b0;
    logic                pclk_pt_a = 1'b0;
    logic                pclk_pt_b = 1'b0;
    logic [N_RST_PT-1:0] rst_pt_a = '0;
    logic [N_RST_PT-1:0] rst_pt_b = '0;
    logic [N_PRE_PT-1:0] pre_pt_a = '0;
    logic [N_PRE_PT-1:0] pre_pt_b = '0;
    logic                rtype_pt_a = 1'b0;
    logic                rtype_pt_b = 1'b0;
    logic [N_LC-1:0]     lc_rst_loc = '0;
    logic [N_LC-1:0]     lc_pre_loc = '0;
    logic                lc_clk_a, lc_clk_b, io_clk_a, io_clk_b;
    logic                lc_tick_a, lc_tick_b, io_tick_a, io_tick_b;
    logic [N_LC-1:0]     lc_rst_eff, lc_pre_eff, lc_rtype;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    glb_ctl_pair #(
        .N_LC     (N_LC),
        .N_RST_PT (N_RST_PT),
        .N_PRE_PT (N_PRE_PT)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_src_a    (cfg_src_a),
        .cfg_iofall_a (cfg_iofall_a),
        .cfg_src_b    (cfg_src_b),
        .cfg_iofall_b (cfg_iofall_b),
        .pin_clk1     (pin_clk1),
        .pin_clk2     (pin_clk2),
        .pclk_pt_a    (pclk_pt_a),
        .pclk_pt_b    (pclk_pt_b),
        .rst_pt_a     (rst_pt_a),
        .rst_pt_b     (rst_pt_b),
        .pre_pt_a     (pre_pt_a),
        .pre_pt_b     (pre_pt_b),
        .rtype_pt_a   (rtype_pt_a),
        .rtype_pt_b   (rtype_pt_b),
        .lc_rst_loc   (lc_rst_loc),
        .lc_pre_loc   (lc_pre_loc),
        .lc_clk_a     (lc_clk_a),
        .lc_clk_b     (lc_clk_b),
        .io_clk_a     (io_clk_a),
        .io_clk_b     (io_clk_b),
        .lc_tick_a    (lc_tick_a),
        .lc_tick_b    (lc_tick_b),
        .io_tick_a    (io_tick_a),
        .io_tick_b    (io_tick_b),
        .lc_rst_eff   (lc_rst_eff),
        .lc_pre_eff   (lc_pre_eff),
        .lc_rtype     (lc_rtype)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Loads config under reset for two edges, releases at a falling edge.
    task automatic do_reset(input logic [1:0] sa, input logic fa,
                            input logic [1:0] sb, input logic fb);
        @(negedge clk);
        rst = 1'b1;
        cfg_src_a = sa; cfg_iofall_a = fa;
        cfg_src_b = sb; cfg_iofall_b = fb;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R4 no tick in reset", {lc_tick_a, io_tick_a, lc_tick_b, io_tick_b}, 0);
        chk("R5 reset eff idle", lc_rst_eff, 0);
        chk("R6 preset eff idle", lc_pre_eff, 0);

        // R1 R2 vector walk on group A
        for (int k = 0; k < N_VEC; k++) begin
            logic [6:0] v;
            v = VEC[k];
            pin_clk1 = 1'b0; pin_clk2 = 1'b0; pclk_pt_a = 1'b0;
            do_reset(v[6:5], v[4], 2'd1, 1'b0);
            pin_clk1  = v[3];
            pin_clk2  = v[2];
            pclk_pt_a = v[1];
            #1;
            chk("R1 source select", lc_clk_a, v[0]);
            chk("R2 io polarity", io_clk_a, v[0] ^ v[4]);
        end

        // R4 tick behaviour: A rising, B falling-edge I/O
        pin_clk1 = 1'b0; pin_clk2 = 1'b0;
        do_reset(2'd0, 1'b0, 2'd0, 1'b1);
        @(negedge clk);
        pin_clk1 = 1'b1;
        #1;
        chk("R4 lc tick on rise", {lc_tick_a, io_tick_a, lc_tick_b, io_tick_b}, 4'b1110);
        @(negedge clk);
        #1;
        chk("R4 tick lasts one cycle", {lc_tick_a, io_tick_a, lc_tick_b}, 3'b000);
        @(negedge clk);
        pin_clk1 = 1'b0;
        #1;
        chk("R4 io tick on falling source", {io_tick_b, lc_tick_a, lc_tick_b}, 3'b100);

        // R4 level already high at reset release
        @(negedge clk);
        rst = 1'b1;
        pin_clk1 = 1'b1;
        #1;
        chk("R4 no tick while reset", lc_tick_a, 1'b0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R4 no tick for level high at release", lc_tick_a, 1'b0);

        // R3 config changes after reset ignored
        pin_clk2 = 1'b0;
        cfg_src_a = 2'd1;
        cfg_iofall_a = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R3 source held", lc_clk_a, 1'b1);
        chk("R3 polarity held", io_clk_a, 1'b1);

        // R5 R6 R7 R8 control fan-out
        pin_clk1 = 1'b0;
        @(negedge clk);
        rst_pt_a = 3'b100;
        #1;
        chk("R5 group A third reset term", lc_rst_eff, 6'b000111);
        rst_pt_a = '0;
        lc_rst_loc = 6'b010000;
        #1;
        chk("R5 local reset single cell", lc_rst_eff, 6'b010000);
        lc_rst_loc = '0;
        pre_pt_b = 2'b10;
        #1;
        chk("R6 group B preset", lc_pre_eff, 6'b111000);
        lc_rst_loc = 6'b001000;
        #1;
        chk("R7 reset beats preset (preset)", lc_pre_eff, 6'b110000);
        chk("R7 reset beats preset (reset)", lc_rst_eff, 6'b001000);
        lc_rst_loc = '0;
        pre_pt_b = '0;
        lc_pre_loc = 6'b000010;
        #1;
        chk("R6 local preset single cell", lc_pre_eff, 6'b000010);
        lc_pre_loc = '0;
        rtype_pt_a = 1'b1;
        #1;
        chk("R8 type term group A", lc_rtype, 6'b000111);
        rtype_pt_a = 1'b0;
        rtype_pt_b = 1'b1;
        #1;
        chk("R8 type term group B", lc_rtype, 6'b111000);
        rtype_pt_b = 1'b0;

        // R9 isolation: group B driven from its product-term clock
        pin_clk1 = 1'b0;
        do_reset(2'd0, 1'b0, 2'd2, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            pclk_pt_b  = ~pclk_pt_b;
            rst_pt_b   = {N_RST_PT{pclk_pt_b}};
            rtype_pt_b = pclk_pt_b;
            #1;
            chk("R9 group B follows its clock", lc_clk_b, pclk_pt_b);
            chk("R9 group A clock untouched", {lc_clk_a, io_clk_a, lc_tick_a, io_tick_a}, 4'b0000);
            chk("R9 group A controls untouched",
                {lc_rst_eff[2:0], lc_pre_eff[2:0], lc_rtype[2:0]}, 9'b0);
            chk("R9 group B controls follow", {lc_rst_eff[5:3], lc_rtype[5:3]},
                {6{pclk_pt_b}});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule